// File: doc/BRIEF.md
# Byte-Commanded Synchronous Serial Engine

This block turns a stream of command bytes into serial-bus activity. A host pushes bytes over a valid/ready byte interface. The engine decodes each opcode, collects the argument bytes that belong to it, and then drives a serial clock, a data-out pin and an 8-bit general-purpose port. It samples a data-in pin while it shifts. Every byte it captures, and every byte it has to report, goes back on a one-cycle response strobe.

Shift opcodes have bit 7 clear, and their low bits select the transfer:
- which directions are active (capture input, drive output, or both);
- the bit order;
- the clock edge on which output data changes;
- the clock edge on which input data is sampled;
- whether the length counts bytes or bits.

Every length is sent as the count minus one. Other opcodes do the following:
- write or read the GPIO port;
- set the clock divisor;
- switch a divide-by-5 prescaler on or off;
- emit clock pulses that carry no data.

The system clock is taken as the engine's base clock. One SCK half-period lasts (divisor+1) base cycles, multiplied by 5 while the prescaler is on.

Top module: `sse_engine`

## Requirements
- R1: After reset, sck, sdo, gpio_out, gpio_oe and rsp_valid are 0 and cmd_ready is 1. The prescaler is on and the divisor is 0, so an SCK high phase lasts 5 clocks.
- R2: An opcode with bit 7 clear and bit 6 clear is a shift command. Its bits mean:
  - bit 5: capture sdi;
  - bit 4: drive sdo;
  - bit 3: least significant bit first (otherwise most significant first);
  - bit 1: count in bits (otherwise in bytes).
- R3: A byte-count shift reads a 16-bit length, low byte first, equal to bytes-1. It then moves 8 bits per byte. A payload byte is read before each byte only when bit 4 is set.
- R4: A bit-count shift reads one length byte whose bits [2:0] equal bits-1, and moves that many bits. One payload byte follows only when bit 4 is set. Captured bits enter at bit 0 and move up in MSB-first order, and enter at bit 7 and move down in LSB-first order.
- R5: With opcode bit 0 set, sdo changes on SCK falling edges, and the first bit is present before the first rising edge. With bit 0 clear, sdo changes on rising edges. With bit 2 clear, sdi is sampled on rising edges; with it set, on falling edges.
- R6: When capture is set, exactly one response byte is returned for each byte (or bit group) clocked. Without capture, a shift returns nothing.
- R7: Opcode 0x80 takes a value byte and then a direction byte; gpio_out and gpio_oe (1 = output) take them after the direction byte. Opcode 0x81 returns one byte equal to gpio_in.
- R8: Opcode 0x86 takes a 16-bit divisor, low byte first. Each SCK half-period lasts (div+1)×P clocks, where P is 5 with the prescaler on and 1 with it off.
- R9: Opcode 0x8B turns the prescaler on and 0x8A turns it off.
- R10: Opcode 0x8E gives N SCK pulses using one length byte N-1 (N from 1 to 256). Opcode 0x8F gives 8×N pulses using a 16-bit length N-1. Neither changes sdo or returns a byte.
- R11: SCK is low whenever no shift is running, and cmd_ready stays low while a shift is running.
- R12: Any other opcode, including one with bit 7 clear and bit 6 set, returns 0xFA and then the opcode in the next cycle. Decoding then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_data | input | 8 | Command byte |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Engine takes the byte this cycle |
| rsp_data | output | 8 | Response byte |
| rsp_valid | output | 1 | One-cycle response strobe |
| sck | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| gpio_in | input | 8 | GPIO pin levels |
| gpio_out | output | 8 | GPIO output values |
| gpio_oe | output | 8 | GPIO direction, 1 = output |

## Verification
The bench builds the engine with its defaults: a 16-bit divisor and a prescale of 5. It then turns the prescaler off with divisor 0, so each SCK half-period lasts one clock. This lets many random shifts cover all edge, order and count-unit combinations in a short run. Directed steps reach the 5-, 3- and 15-cycle half-periods, multi-pulse clock-only commands, and the two error forms. Lengths near the 16-bit limit are not reached.

// File: rtl/sse_pkg.sv
package sse_pkg;
  typedef enum logic [3:0] {
    K_SHIFT, K_GSET, K_GRD, K_DIV, K_PRE_ON, K_PRE_OFF, K_CLKB, K_CLKY, K_BAD
  } op_kind_e;

  typedef enum logic [2:0] {S_OP, S_A0, S_A1, S_PAY, S_RUN, S_ERR} dec_st_e;

  localparam logic [7:0] ERR_TAG = 8'hFA;

  function automatic op_kind_e op_kind(input logic [7:0] op);
    if (!op[7]) return op[6] ? K_BAD : K_SHIFT;
    case (op)
      8'h80: return K_GSET;
      8'h81: return K_GRD;
      8'h86: return K_DIV;
      8'h8A: return K_PRE_OFF;
      8'h8B: return K_PRE_ON;
      8'h8E: return K_CLKB;
      8'h8F: return K_CLKY;
      default: return K_BAD;
    endcase
  endfunction

  // clocks per SCK half-period
  function automatic logic [31:0] half_cycles(input logic [31:0] div, input logic pre,
                                              input logic [31:0] pre_div);
    return (div + 32'd1) * (pre ? pre_div : 32'd1);
  endfunction
endpackage

// File: rtl/sse_gpio.sv
module sse_gpio #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  input  logic [W-1:0] dir,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else if (load) begin
      pin_out <= val;
      pin_oe  <= dir;
    end
  end
endmodule

// File: rtl/sse_shifter.sv
module sse_shifter #(
  parameter int HALF_W = 20,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [7:0]        tx,
  input  logic [CNT_W-1:0]  nbits,
  input  logic              lsb,
  input  logic              icn,
  input  logic              ocn,
  input  logic              drv,
  input  logic [HALF_W-1:0] half_m1,
  input  logic              sdi,
  output logic              sck,
  output logic              sdo,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rx
);
  typedef enum logic [1:0] {H_IDLE, H_RUN, H_FIN} hst_e;
  hst_e              st_q;
  logic [HALF_W-1:0] cnt_q, hm_q;
  logic [CNT_W-1:0]  bit_q, nb_q;
  logic [7:0]        txq;
  logic              f_lsb, f_icn, f_ocn, f_drv;

  logic       tick, last_bit, cur_bit;
  logic [7:0] tx_adv, rx_samp;
  assign tick     = (st_q == H_RUN) && (cnt_q == '0);
  assign last_bit = (bit_q == nb_q - 1'b1);
  assign cur_bit  = f_lsb ? txq[0] : txq[7];
  assign tx_adv   = f_lsb ? {1'b0, txq[7:1]} : {txq[6:0], 1'b0};
  assign rx_samp  = f_lsb ? {sdi, rx[7:1]} : {rx[6:0], sdi};
  assign busy     = (st_q != H_IDLE);
  assign done     = (st_q == H_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= H_IDLE; cnt_q <= '0; hm_q <= '0; bit_q <= '0; nb_q <= '0;
      txq <= '0; rx <= '0; sck <= 1'b0; sdo <= 1'b0;
      f_lsb <= 1'b0; f_icn <= 1'b0; f_ocn <= 1'b0; f_drv <= 1'b0;
    end else if (go && st_q != H_RUN) begin
      st_q <= H_RUN; cnt_q <= half_m1; hm_q <= half_m1;
      bit_q <= '0; nb_q <= nbits; rx <= '0;
      f_lsb <= lsb; f_icn <= icn; f_ocn <= ocn; f_drv <= drv;
      if (drv && ocn) begin
        sdo <= lsb ? tx[0] : tx[7];
        txq <= lsb ? {1'b0, tx[7:1]} : {tx[6:0], 1'b0};
      end else begin
        txq <= tx;
      end
    end else if (st_q == H_RUN) begin
      if (!tick) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= hm_q;
        sck   <= ~sck;
        if (!sck) begin
          if (!f_icn) rx <= rx_samp;
          if (f_drv && !f_ocn) begin sdo <= cur_bit; txq <= tx_adv; end
        end else begin
          if (f_icn) rx <= rx_samp;
          if (last_bit) st_q <= H_FIN;
          else begin
            bit_q <= bit_q + 1'b1;
            if (f_drv && f_ocn) begin sdo <= cur_bit; txq <= tx_adv; end
          end
        end
      end
    end else begin
      st_q <= H_IDLE;
    end
  end

  AST_SCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != $past(sck)) |-> $past(st_q == H_RUN && cnt_q == '0)); // R8
  AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st_q != H_RUN)); // R11
  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == H_RUN) |-> (bit_q < nb_q)); // R4
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != H_RUN) |-> !sck); // R11
endmodule

// File: rtl/sse_engine.sv
module sse_engine
  import sse_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int PRESCALE = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cmd_data,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  output logic [7:0] rsp_data,
  output logic       rsp_valid,
  output logic       sck,
  output logic       sdo,
  input  logic       sdi,
  input  logic [7:0] gpio_in,
  output logic [7:0] gpio_out,
  output logic [7:0] gpio_oe
);
  localparam int HALF_W = DIV_W + $clog2(PRESCALE) + 1;
  localparam int CNT_W  = 9;

  dec_st_e          st_q, st_d;
  logic [7:0]       op_q, a0_q, emit_d, go_tx;
  logic [15:0]      rem_q;
  logic [CNT_W-1:0] nbits_q, nb_go;
  logic [DIV_W-1:0] div_q;
  logic             pre_q, acc, go, emit, gload, single, drv, cap;
  logic             shf_busy, shf_done;
  logic [7:0]       shf_rx;
  logic [HALF_W-1:0] half_m1;
  op_kind_e         kq, kin;

  assign kq        = op_kind(op_q);
  assign kin       = op_kind(cmd_data);
  assign single    = (kq == K_CLKB) || (kq == K_SHIFT && op_q[1]);
  assign drv       = (kq == K_SHIFT) && op_q[4];
  assign cap       = (kq == K_SHIFT) && op_q[5];
  assign cmd_ready = (st_q == S_OP) || (st_q == S_A0) || (st_q == S_A1) || (st_q == S_PAY);
  assign acc       = cmd_valid && cmd_ready;
  assign half_m1   = HALF_W'(half_cycles(32'(div_q), pre_q, 32'(PRESCALE)) - 32'd1);

  always_comb begin
    st_d = st_q; go = 1'b0; go_tx = '0; nb_go = nbits_q;
    emit = 1'b0; emit_d = '0; gload = 1'b0;
    case (st_q)
      S_OP: if (acc) begin
        case (kin)
          K_SHIFT, K_GSET, K_DIV, K_CLKB, K_CLKY: st_d = S_A0;
          K_GRD: begin emit = 1'b1; emit_d = gpio_in; end
          K_BAD: begin emit = 1'b1; emit_d = ERR_TAG; st_d = S_ERR; end
          default: ;
        endcase
      end
      S_A0: if (acc) begin
        if (single) begin
          nb_go = (kq == K_CLKB) ? CNT_W'(cmd_data) + 1'b1 : CNT_W'(cmd_data[2:0]) + 1'b1;
          if (drv) st_d = S_PAY; else begin st_d = S_RUN; go = 1'b1; end
        end else st_d = S_A1;
      end
      S_A1: if (acc) begin
        if (kq == K_GSET) begin gload = 1'b1; st_d = S_OP; end
        else if (kq == K_DIV) st_d = S_OP;
        else begin
          nb_go = CNT_W'(8);
          if (drv) st_d = S_PAY; else begin st_d = S_RUN; go = 1'b1; end
        end
      end
      S_PAY: if (acc) begin go = 1'b1; go_tx = cmd_data; st_d = S_RUN; end
      S_RUN: if (shf_done) begin
        if (cap) begin emit = 1'b1; emit_d = shf_rx; end
        if (rem_q == '0) st_d = S_OP;
        else if (drv) st_d = S_PAY;
        else begin st_d = S_RUN; go = 1'b1; end
      end
      S_ERR: begin emit = 1'b1; emit_d = op_q; st_d = S_OP; end
      default: st_d = S_OP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_OP; op_q <= '0; a0_q <= '0; rem_q <= '0; nbits_q <= '0;
      div_q <= '0; pre_q <= 1'b1; rsp_valid <= 1'b0; rsp_data <= '0;
    end else begin
      st_q      <= st_d;
      rsp_valid <= emit;
      if (emit) rsp_data <= emit_d;
      if (acc && st_q == S_OP) begin
        op_q <= cmd_data;
        if (kin == K_PRE_ON)  pre_q <= 1'b1;
        if (kin == K_PRE_OFF) pre_q <= 1'b0;
      end
      if (acc && st_q == S_A0) begin
        a0_q <= cmd_data;
        if (single) begin rem_q <= '0; nbits_q <= nb_go; end
      end
      if (acc && st_q == S_A1) begin
        if (kq == K_DIV) div_q <= DIV_W'({cmd_data, a0_q});
        else if (kq != K_GSET) begin rem_q <= {cmd_data, a0_q}; nbits_q <= nb_go; end
      end
      if (st_q == S_RUN && shf_done && rem_q != '0) rem_q <= rem_q - 1'b1;
    end
  end

  sse_shifter #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .go(go), .tx(go_tx), .nbits(nb_go),
    .lsb(op_q[3]), .icn(op_q[2]), .ocn(op_q[0]), .drv(drv), .half_m1(half_m1),
    .sdi(sdi), .sck(sck), .sdo(sdo), .busy(shf_busy), .done(shf_done), .rx(shf_rx)
  );

  sse_gpio #(.W(8)) u_gpio (
    .clk(clk), .rst_n(rst_n), .load(gload), .val(a0_q), .dir(cmd_data),
    .pin_out(gpio_out), .pin_oe(gpio_oe)
  );

  AST_ACCEPT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> !shf_busy); // R11
  AST_CAP_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_done && cap) |=> rsp_valid); // R6
  AST_ERR_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ERR) |-> (rsp_valid && rsp_data == ERR_TAG)); // R12
  AST_ERR_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ERR) |=> (rsp_valid && rsp_data == $past(op_q))); // R12
  AST_GPIO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> ($stable(gpio_oe) && $stable(gpio_out))); // R7
endmodule

// File: tb/tb_sse_engine.sv
`timescale 1ns/1ps
module tb_sse_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cmd_data = '0, gpio_in = '0;
  logic cmd_valid = 1'b0, sdi = 1'b0;
  logic cmd_ready, rsp_valid, sck, sdo;
  logic [7:0] rsp_data, gpio_out, gpio_oe;

  always #2.5 clk = ~clk;

  sse_engine dut (.clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .rsp_data(rsp_data), .rsp_valid(rsp_valid), .sck(sck),
    .sdo(sdo), .sdi(sdi), .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe));

  int checks = 0, fails = 0, cyc = 0;
  bit done_flag = 0;

  // serial-slave model state
  logic sb [0:63];
  logic gb [0:63];
  logic [7:0] rq [0:255];
  int si = 0, gi = 0, rises = 0, hcnt = 0, last_hw = 0, rn = 0;
  logic psck = 1'b0, m_icn = 1'b0, m_ocn = 1'b0, arm_req = 1'b0, arm_ack = 1'b0;

  always @(negedge clk) begin
    if (rsp_valid) begin rq[rn & 255] = rsp_data; rn++; end
    if (arm_req != arm_ack) begin
      arm_ack = arm_req; si = 0; gi = 0; rises = 0;
      if (!m_icn) sdi = sb[0];
    end else begin
      if (sck && !psck) begin
        rises++;
        if (m_ocn) begin gb[gi & 63] = sdo; gi++; end
        if (m_icn) begin sdi = sb[si & 63]; si++; end
      end
      if (!sck && psck) begin
        last_hw = hcnt;
        if (!m_ocn) begin gb[gi & 63] = sdo; gi++; end
        if (!m_icn) begin si++; sdi = sb[si & 63]; end
      end
    end
    hcnt = sck ? hcnt + 1 : 0;
    psck = sck;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    do @(negedge clk); while (!cmd_ready);
    cmd_data = b; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_cmd();
    while (!cmd_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic arm();
    @(posedge clk); #1 arm_req = ~arm_req;
    @(negedge clk);
  endtask

  function automatic logic wire_bit(input logic [7:0] v, input int i, input logic lsbf);
    return lsbf ? v[i] : v[7 - i];
  endfunction

  function automatic logic [7:0] fold_in(input logic [7:0] acc, input logic b, input logic lsbf);
    return lsbf ? {b, acc[7:1]} : {acc[6:0], b};
  endfunction

  task automatic run_shift(input logic [7:0] op, input int units);
    logic [7:0] pay [0:3];
    logic bitm, lsbf, drv, cap;
    int nbytes, nb, bad, rn0;
    logic [7:0] acc;
    bitm = op[1]; lsbf = op[3]; drv = op[4]; cap = op[5];
    nbytes = bitm ? 1 : units;
    nb = bitm ? units : 8;
    for (int k = 0; k < 4; k++) pay[k] = 8'($urandom);
    for (int i = 0; i < 64; i++) sb[i] = 1'($urandom);
    m_icn = op[2]; m_ocn = op[0];
    arm();
    rn0 = rn;
    put(op);
    if (bitm) put(8'(units - 1));
    else begin put(8'(units - 1)); put(8'h00); end
    if (drv) for (int k = 0; k < nbytes; k++) put(pay[k]);
    finish_cmd();
    if (bitm) chk(rises == nb, "R4 bit-count pulses", rises, nb);
    else      chk(rises == nbytes * 8, "R3 byte-count pulses", rises, nbytes * 8);
    chk(sck == 1'b0, "R11 sck idle low", sck, 0);
    if (drv) begin
      bad = 0;
      for (int k = 0; k < nbytes; k++)
        for (int i = 0; i < nb; i++)
          if (gb[k * nb + i] !== wire_bit(pay[k], i, lsbf)) bad++;
      chk(bad == 0, "R5 sdo bit stream (order/edge)", bad, 0);
    end
    chk((rn - rn0) == (cap ? nbytes : 0), "R6 response count", rn - rn0, cap ? nbytes : 0);
    if (cap) for (int k = 0; k < nbytes; k++) begin
      acc = '0;
      for (int i = 0; i < nb; i++) acc = fold_in(acc, sb[k * nb + i], lsbf);
      chk(rq[(rn0 + k) & 255] == acc, bitm ? "R4 captured bits" : "R2 captured byte",
          rq[(rn0 + k) & 255], acc);
    end
  endtask

  initial begin
    int rn0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(sck == 0 && sdo == 0 && rsp_valid == 0, "R1 reset outputs", {sck, sdo, rsp_valid}, 0);
    chk(gpio_out == 0 && gpio_oe == 0, "R1 reset gpio", {gpio_out, gpio_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);

    // default timing: prescale on, divisor 0 -> 5-clock half period
    m_icn = 0; m_ocn = 0; arm();
    put(8'h8E); put(8'h00);
    finish_cmd();
    chk(last_hw == 5, "R1 default half period", last_hw, 5);
    chk(rises == 1, "R10 single pulse", rises, 1);

    put(8'h8A); finish_cmd();
    arm(); put(8'h8E); put(8'h00); finish_cmd();
    chk(last_hw == 1, "R9 prescale off", last_hw, 1);

    put(8'h86); put(8'h02); put(8'h00); finish_cmd();
    arm(); put(8'h8E); put(8'h00); finish_cmd();
    chk(last_hw == 3, "R8 divisor 2", last_hw, 3);

    put(8'h8B); finish_cmd();
    arm(); put(8'h8E); put(8'h00); finish_cmd();
    chk(last_hw == 15, "R9 prescale on with divisor 2", last_hw, 15);

    put(8'h86); put(8'h00); put(8'h00); finish_cmd();

    // busy: ready held low during a clock-only burst (prescale still on)
    arm(); rn0 = rn;
    put(8'h8F); put(8'h01); put(8'h00);
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R11 ready low while shifting", cmd_ready, 0);
    finish_cmd();
    chk(rises == 16, "R10 byte clock pulses", rises, 16);
    chk(rn == rn0, "R10 no response from clocking", rn - rn0, 0);

    put(8'h8A); finish_cmd();
    arm(); put(8'h8E); put(8'h09); finish_cmd();
    chk(rises == 10, "R10 bit clock pulses", rises, 10);

    // GPIO
    put(8'h80); put(8'hA5); put(8'h0F); finish_cmd();
    chk(gpio_out == 8'hA5, "R7 gpio value", gpio_out, 8'hA5);
    chk(gpio_oe == 8'h0F, "R7 gpio direction", gpio_oe, 8'h0F);
    gpio_in = 8'h3C; rn0 = rn;
    put(8'h81); finish_cmd();
    chk(rn - rn0 == 1 && rq[rn0 & 255] == 8'h3C, "R7 gpio read", rq[rn0 & 255], 8'h3C);

    // errors
    rn0 = rn;
    put(8'h8C); finish_cmd();
    chk(rn - rn0 == 2 && rq[rn0 & 255] == 8'hFA && rq[(rn0 + 1) & 255] == 8'h8C,
        "R12 bad opcode pair", {rq[rn0 & 255], rq[(rn0 + 1) & 255]}, 16'hFA8C);
    rn0 = rn;
    put(8'h40); finish_cmd();
    chk(rn - rn0 == 2 && rq[(rn0 + 1) & 255] == 8'h40, "R12 mode-bit opcode", rq[(rn0 + 1) & 255], 8'h40);

    // directed: every edge combination, both orders, full duplex
    for (int e = 0; e < 8; e++)
      run_shift(8'h30 | (e[2] ? 8'h08 : 8'h00) | (e[1] ? 8'h04 : 8'h00) | (e[0] ? 8'h01 : 8'h00), 2);
    run_shift(8'h33, 1);
    run_shift(8'h3B, 8);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [7:0] op;
      op = {2'b00, 6'($urandom)};
      run_shift(op, op[1] ? 1 + int'($urandom % 8) : 1 + int'($urandom % 3));
    end

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule